// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block sends frames that software has built in memory as a ring of transmit buffer descriptors. A descriptor is two 32-bit words. The first word holds a 16-bit flag field in its upper half and a 16-bit buffer length in its lower half. The second word holds the byte address of the buffer. Software marks descriptors as ready and pulses a kick input while the controller is enabled. The engine then walks the ring from its current pointer. For each ready descriptor it fetches the buffer through a request/acknowledge word port and streams the bytes out on a byte interface with a valid/ready handshake. It then writes the descriptor back with the ready flag cleared and moves to the next descriptor.

A frame may span several descriptors and ends with the one that carries the last flag. The total length of a frame is capped, and an event reports when that cap trims a buffer. Single-cycle event pulses report each consumed buffer and each completed frame. A pass ends at the first descriptor that is not ready, or after a fixed number of descriptors. The ring pointer is kept between passes.

Top module: `txring_engine`

## Requirements
- R1: After synchronous reset the block drives no memory request, no valid byte and no event pulse.
- R2: A kick is accepted only while `enable` is 1. A kick given while `enable` is 0 causes no memory access and no output.
- R3: A pass reads the word at the current pointer, which holds flags in bits 31:16 and length in bits 15:0, then the word at pointer+4, which holds the buffer byte address. Flag bit 15 is ready, bit 13 is wrap and bit 11 is last. A pass stops at the first descriptor whose ready bit is 0 and leaves that descriptor untouched. A memory request holds its address until acknowledged.
- R4: Buffer bytes leave in address order, taken from each fetched aligned word most-significant byte first, whatever the alignment of the buffer address. An offered byte stays stable until it is accepted.
- R5: `tx_last` marks the final byte of a descriptor that has the last flag. Descriptors without that flag continue the same frame.
- R6: After its bytes are consumed, a descriptor's first word is written back with flag bit 15 cleared and every other bit unchanged, including the original length.
- R7: The next descriptor is at the ring start when the wrap flag is set, and at the current pointer plus 8 otherwise. The pointer is kept for the next kick.
- R8: Writing the ring start register clears the two low bits of the written value and reloads the current pointer with the result.
- R9: Every written-back descriptor raises `ev_txbuf` for one cycle. A descriptor with the last flag also raises `ev_txframe` in the same cycle and starts a new frame count.
- R10: When a descriptor would take the frame past MAX_FRAME bytes (2032), its copy is trimmed to the remaining room and `ev_babble` pulses once.
- R11: A single pass handles at most MAX_DESC (1024) descriptors.
- R12: A kick that arrives while a pass is running is remembered and starts a new pass after the current one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Controller enable; kicks are ignored while low |
| kick | input | 1 | Transmit start pulse |
| ring_base_we | input | 1 | Write strobe for the ring start register |
| ring_base_wdata | input | 32 | Ring start byte address |
| mem_req | output | 1 | Memory word request, held until acknowledged |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle acknowledge; read data valid with it |
| mem_rdata | input | 32 | Read data |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | Frame byte valid |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Downstream accepts the byte |
| ev_txbuf | output | 1 | Pulse: descriptor consumed |
| ev_txframe | output | 1 | Pulse: frame finished |
| ev_babble | output | 1 | Pulse: frame length trimmed |

## Verification
The main function is driven with several patterns:
- A single aligned one-descriptor frame whose spare flag bits are set, which exposes errors in write-back masking.
- Frames spread over unaligned buffers while the byte sink stalls on a regular cycle, which tells byte ordering and offset skipping apart from handshake stalls.
- A short ring with a wrap flag and a misaligned start address, which separates wrap-to-base from plus-8 stepping and shows the low-bit masking.
- An oversized two-descriptor frame followed by a short one, which separates trimming from the frame-count restart.
- A 1026-entry ring, which shows the per-pass limit.
- A kick sent during a stalled pass, which shows that the second pass runs only because the pending kick was kept.

// File: rtl/txr_pkg.sv
package txr_pkg;

    localparam int ADDR_W     = 32;
    localparam int FLAG_READY = 15;
    localparam int FLAG_WRAP  = 13;
    localparam int FLAG_LAST  = 11;
    localparam int DESC_STEP  = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_PTR,
        ST_DATA,
        ST_FETCH,
        ST_DRAIN,
        ST_WBACK
    } txr_state_e;

    typedef struct packed {
        logic [15:0] flags;
        logic [15:0] len;
    } txr_desc_t;

    // bytes usable from one aligned word starting at byte offset off
    function automatic logic [2:0] chunk_len(input logic [1:0] off, input logic [15:0] remain);
        logic [2:0] room;
        room = 3'd4 - {1'b0, off};
        if (remain < {13'd0, room}) return remain[2:0];
        return room;
    endfunction

endpackage

// File: rtl/txr_wordser.sv
module txr_wordser
    import txr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ld,
    input  logic [31:0] ld_word,
    input  logic [1:0]  ld_first,
    input  logic [2:0]  ld_cnt,
    input  logic        ld_eof,
    output logic        idle,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    output logic        tx_last,
    input  logic        tx_ready
);

    logic [31:0] word_q;
    logic [1:0]  idx_q;
    logic [2:0]  cnt_q;
    logic        eof_q;
    logic [31:0] shifted;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            idx_q  <= '0;
            cnt_q  <= '0;
            eof_q  <= 1'b0;
        end else if (ld && cnt_q == 3'd0) begin
            word_q <= ld_word;
            idx_q  <= ld_first;
            cnt_q  <= ld_cnt;
            eof_q  <= ld_eof;
        end else if (cnt_q != 3'd0 && tx_ready) begin
            idx_q <= idx_q + 2'd1;
            cnt_q <= cnt_q - 3'd1;
        end
    end

    assign shifted  = word_q << {idx_q, 3'b000};
    assign tx_data  = shifted[31:24];
    assign tx_valid = (cnt_q != 3'd0);
    assign tx_last  = eof_q && (cnt_q == 3'd1);
    assign idle     = (cnt_q == 3'd0);

    // R4
    byte_hold_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

    // R5
    last_valid_chk: assert property (@(posedge clk) disable iff (rst)
        tx_last |-> tx_valid);

endmodule

// File: rtl/txr_seq.sv
module txr_seq
    import txr_pkg::*;
#(
    parameter int MAX_FRAME = 2032,
    parameter int MAX_DESC  = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              kick,
    input  logic              ring_base_we,
    input  logic [ADDR_W-1:0] ring_base_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              ser_ld,
    output logic [1:0]        ser_first,
    output logic [2:0]        ser_cnt,
    output logic              ser_eof,
    input  logic              ser_idle,
    output logic              ev_txbuf,
    output logic              ev_txframe,
    output logic              ev_babble
);

    localparam int FLW = $clog2(MAX_FRAME + 1);
    localparam int DCW = $clog2(MAX_DESC + 1);

    txr_state_e        state;
    txr_desc_t         desc;
    logic [ADDR_W-1:0] ring_base;
    logic [ADDR_W-1:0] cur_ptr;
    logic [ADDR_W-1:0] data_addr;
    logic [FLW-1:0]    frame_len;
    logic [DCW-1:0]    desc_cnt;
    logic [15:0]       remain;
    logic              pend;
    logic [15:0]       room;
    logic [2:0]        chunk;
    logic [DCW-1:0]    cnt_next;

    assign room     = 16'(MAX_FRAME) - 16'(frame_len);
    assign chunk    = chunk_len(data_addr[1:0], remain);
    assign cnt_next = desc_cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            desc       <= '0;
            ring_base  <= '0;
            cur_ptr    <= '0;
            data_addr  <= '0;
            frame_len  <= '0;
            desc_cnt   <= '0;
            remain     <= '0;
            pend       <= 1'b0;
            ev_txbuf   <= 1'b0;
            ev_txframe <= 1'b0;
            ev_babble  <= 1'b0;
        end else begin
            ev_txbuf   <= 1'b0;
            ev_txframe <= 1'b0;
            ev_babble  <= 1'b0;
            if (ring_base_we) begin
                ring_base <= ring_base_wdata & ~ADDR_W'(3);
                cur_ptr   <= ring_base_wdata & ~ADDR_W'(3);
            end
            unique case (state)
                ST_IDLE: begin
                    if (pend) begin
                        pend     <= 1'b0;
                        desc_cnt <= '0;
                        state    <= ST_HDR;
                    end
                end
                ST_HDR: begin
                    if (mem_ack) begin
                        desc.flags <= mem_rdata[31:16];
                        desc.len   <= mem_rdata[15:0];
                        state      <= mem_rdata[16 + FLAG_READY] ? ST_PTR : ST_IDLE;
                    end
                end
                ST_PTR: begin
                    if (mem_ack) begin
                        data_addr <= mem_rdata;
                        if (desc.len > room) begin
                            remain    <= room;
                            frame_len <= FLW'(MAX_FRAME);
                            ev_babble <= 1'b1;
                        end else begin
                            remain    <= desc.len;
                            frame_len <= frame_len + FLW'(desc.len);
                        end
                        state <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    state <= (remain == 16'd0) ? ST_WBACK : ST_FETCH;
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        data_addr <= data_addr + ADDR_W'(chunk);
                        remain    <= remain - 16'(chunk);
                        state     <= ST_DRAIN;
                    end
                end
                ST_DRAIN: begin
                    if (ser_idle) state <= ST_DATA;
                end
                ST_WBACK: begin
                    if (mem_ack) begin
                        ev_txbuf <= 1'b1;
                        if (desc.flags[FLAG_LAST]) begin
                            ev_txframe <= 1'b1;
                            frame_len  <= '0;
                        end
                        cur_ptr  <= desc.flags[FLAG_WRAP] ? ring_base
                                                          : cur_ptr + ADDR_W'(DESC_STEP);
                        desc_cnt <= cnt_next;
                        state    <= (cnt_next == DCW'(MAX_DESC)) ? ST_IDLE : ST_HDR;
                    end
                end
                default: state <= ST_IDLE;
            endcase
            if (kick && enable) pend <= 1'b1;
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_ptr;
        mem_wdata = {desc.flags & ~(16'd1 << FLAG_READY), desc.len};
        unique case (state)
            ST_HDR:   mem_req = 1'b1;
            ST_PTR:   begin mem_req = 1'b1; mem_addr = cur_ptr + ADDR_W'(4); end
            ST_FETCH: begin mem_req = 1'b1; mem_addr = data_addr & ~ADDR_W'(3); end
            ST_WBACK: begin mem_req = 1'b1; mem_we = 1'b1; end
            default:  ;
        endcase
    end

    assign ser_ld    = (state == ST_FETCH) && mem_ack;
    assign ser_first = data_addr[1:0];
    assign ser_cnt   = chunk;
    assign ser_eof   = desc.flags[FLAG_LAST] && (remain == 16'(chunk));

    // R3
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R8
    word_align_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_addr[1:0] == 2'b00);

    // R9
    frame_implies_buf_chk: assert property (@(posedge clk) disable iff (rst)
        ev_txframe |-> ev_txbuf);

    // R10
    frame_cap_chk: assert property (@(posedge clk) disable iff (rst)
        frame_len <= FLW'(MAX_FRAME));

    // R11
    desc_limit_chk: assert property (@(posedge clk) disable iff (rst)
        desc_cnt <= DCW'(MAX_DESC));

    // R12
    pend_start_chk: assert property (@(posedge clk) disable iff (rst)
        state == ST_IDLE && pend |=> state == ST_HDR);

endmodule

// File: rtl/txring_engine.sv
module txring_engine
    import txr_pkg::*;
#(
    parameter int MAX_FRAME = 2032,
    parameter int MAX_DESC  = 1024
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        enable,
    input  logic        kick,
    input  logic        ring_base_we,
    input  logic [31:0] ring_base_wdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    output logic        tx_last,
    input  logic        tx_ready,
    output logic        ev_txbuf,
    output logic        ev_txframe,
    output logic        ev_babble
);

    logic       ser_ld;
    logic [1:0] ser_first;
    logic [2:0] ser_cnt;
    logic       ser_eof;
    logic       ser_idle;

    txr_seq #(
        .MAX_FRAME (MAX_FRAME),
        .MAX_DESC  (MAX_DESC)
    ) u_seq (
        .clk             (clk),
        .rst             (rst),
        .enable          (enable),
        .kick            (kick),
        .ring_base_we    (ring_base_we),
        .ring_base_wdata (ring_base_wdata),
        .mem_req         (mem_req),
        .mem_we          (mem_we),
        .mem_addr        (mem_addr),
        .mem_wdata       (mem_wdata),
        .mem_ack         (mem_ack),
        .mem_rdata       (mem_rdata),
        .ser_ld          (ser_ld),
        .ser_first       (ser_first),
        .ser_cnt         (ser_cnt),
        .ser_eof         (ser_eof),
        .ser_idle        (ser_idle),
        .ev_txbuf        (ev_txbuf),
        .ev_txframe      (ev_txframe),
        .ev_babble       (ev_babble)
    );

    txr_wordser u_ser (
        .clk      (clk),
        .rst      (rst),
        .ld       (ser_ld),
        .ld_word  (mem_rdata),
        .ld_first (ser_first),
        .ld_cnt   (ser_cnt),
        .ld_eof   (ser_eof),
        .idle     (ser_idle),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_last  (tx_last),
        .tx_ready (tx_ready)
    );

endmodule

// File: tb/txring_engine_tb.sv
`timescale 1ns/1ps
module txring_engine_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b1;
    logic        kick = 1'b0;
    logic        ring_base_we = 1'b0;
    logic [31:0] ring_base_wdata = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [7:0]  tx_data;
    logic        tx_valid, tx_last;
    logic        tx_ready = 1'b1;
    logic        ev_txbuf, ev_txframe, ev_babble;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    bit stall_mode = 0;
    bit stall_hold = 0;
    int cyc = 0;
    int cnt_buf, cnt_frame, cnt_bab, cnt_req;
    logic [31:0] mem [int unsigned];
    byte unsigned rx_q[$];
    bit           rxl_q[$];
    byte unsigned exp_q[$];
    bit           expl_q[$];

    always #2.5 clk = ~clk;

    txring_engine u_dut (
        .clk(clk), .rst(rst), .enable(enable), .kick(kick),
        .ring_base_we(ring_base_we), .ring_base_wdata(ring_base_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last),
        .tx_ready(tx_ready), .ev_txbuf(ev_txbuf), .ev_txframe(ev_txframe),
        .ev_babble(ev_babble)
    );

    function automatic byte unsigned pat(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    function automatic logic [31:0] rd_word(input logic [31:0] a);
        logic [31:0] b;
        b = a & ~32'd3;
        if (mem.exists(b >> 2)) return mem[b >> 2];
        if (b >= 32'h100000) return {pat(b), pat(b + 1), pat(b + 2), pat(b + 3)};
        return 32'd0;
    endfunction

    // memory model: one-cycle acknowledge
    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                if (mem_we) mem[mem_addr >> 2] = mem_wdata;
                else mem_rdata <= rd_word(mem_addr);
            end
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst) begin
            if (tx_valid && tx_ready) begin
                rx_q.push_back(tx_data);
                rxl_q.push_back(tx_last);
            end
            if (ev_txbuf) cnt_buf++;
            if (ev_txframe) cnt_frame++;
            if (ev_babble) cnt_bab++;
            if (mem_req) cnt_req++;
        end
    end

    always @(negedge clk)
        tx_ready <= stall_hold ? 1'b0 : (stall_mode ? (cyc % 3 != 0) : 1'b1);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_obs();
        rx_q.delete(); rxl_q.delete(); exp_q.delete(); expl_q.delete();
        cnt_buf = 0; cnt_frame = 0; cnt_bab = 0; cnt_req = 0;
    endtask

    task automatic set_desc(input logic [31:0] a, input logic [15:0] fl,
                            input logic [15:0] len, input logic [31:0] bufa);
        mem[a >> 2] = {fl, len};
        mem[(a + 4) >> 2] = bufa;
    endtask

    task automatic expect_bytes(input logic [31:0] bufa, input int n, input bit last);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(pat(bufa + i));
            expl_q.push_back(last && (i == n - 1));
        end
    endtask

    task automatic do_kick();
        @(negedge clk) kick = 1'b1;
        @(negedge clk) kick = 1'b0;
    endtask

    task automatic set_base(input logic [31:0] v);
        @(negedge clk) begin ring_base_we = 1'b1; ring_base_wdata = v; end
        @(negedge clk) ring_base_we = 1'b0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 10) begin
            @(negedge clk);
            if (!mem_req && !tx_valid) quiet++; else quiet = 0;
        end
    endtask

    task automatic cmp_stream(input string req);
        int bad = 0;
        chk(rx_q.size() == exp_q.size(), req, rx_q.size(), exp_q.size());
        if (rx_q.size() == exp_q.size())
            for (int i = 0; i < rx_q.size(); i++)
                if (rx_q[i] != exp_q[i] || rxl_q[i] != expl_q[i]) bad++;
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        // R1
        chk(!mem_req && !tx_valid, "R1", {mem_req, tx_valid}, 0);
        chk(!ev_txbuf && !ev_txframe && !ev_babble, "R1", {ev_txbuf, ev_txframe, ev_babble}, 0);
    endtask

    task automatic t_single();
        clear_obs();
        set_base(32'h1000);
        set_desc(32'h1000, 16'h8C05, 16'd6, 32'h100000);
        set_desc(32'h1008, 16'h0000, 16'd0, 32'h0);
        expect_bytes(32'h100000, 6, 1);
        do_kick(); wait_idle();
        cmp_stream("R4_R5 single aligned frame");
        // R6
        chk(rd_word(32'h1000) == 32'h0C050006, "R6", rd_word(32'h1000), 32'h0C050006);
        // R3
        chk(rd_word(32'h1008) == 32'h0, "R3", rd_word(32'h1008), 0);
        // R9
        chk(cnt_buf == 1 && cnt_frame == 1 && cnt_bab == 0, "R9", {cnt_buf, cnt_frame}, 64'h100000001);
    endtask

    task automatic t_multi();
        clear_obs();
        stall_mode = 1;
        set_base(32'h2000);
        set_desc(32'h2000, 16'h8000, 16'd5, 32'h100103);
        set_desc(32'h2008, 16'h8800, 16'd3, 32'h100201);
        set_desc(32'h2010, 16'h8800, 16'd4, 32'h100300);
        set_desc(32'h2018, 16'h0000, 16'd0, 32'h0);
        expect_bytes(32'h100103, 5, 0);
        expect_bytes(32'h100201, 3, 1);
        expect_bytes(32'h100300, 4, 1);
        do_kick(); wait_idle();
        stall_mode = 0;
        cmp_stream("R4_R5 unaligned multi-buffer stalled");
        // R9
        chk(cnt_buf == 3 && cnt_frame == 2, "R9", {cnt_buf, cnt_frame}, 64'h300000002);
        // R6
        chk(rd_word(32'h2000) == 32'h00000005, "R6", rd_word(32'h2000), 32'h5);
    endtask

    task automatic t_wrap();
        clear_obs();
        set_base(32'h3001);
        set_desc(32'h3000, 16'h8800, 16'd2, 32'h100400);
        set_desc(32'h3008, 16'hA800, 16'd2, 32'h100500);
        set_desc(32'h3010, 16'h8800, 16'd2, 32'h100700);
        expect_bytes(32'h100400, 2, 1);
        expect_bytes(32'h100500, 2, 1);
        do_kick(); wait_idle();
        // R8
        cmp_stream("R8 masked ring start");
        // R7
        chk(cnt_buf == 2, "R7", cnt_buf, 2);
        chk(rd_word(32'h3010) == 32'h88000002, "R7", rd_word(32'h3010), 32'h88000002);
        clear_obs();
        set_desc(32'h3000, 16'h8800, 16'd1, 32'h100600);
        expect_bytes(32'h100600, 1, 1);
        do_kick(); wait_idle();
        cmp_stream("R7 wrapped pointer kept");
    endtask

    task automatic t_disabled();
        clear_obs();
        @(negedge clk) enable = 1'b0;
        set_base(32'h4000);
        set_desc(32'h4000, 16'h8800, 16'd2, 32'h100800);
        set_desc(32'h4008, 16'h0000, 16'd0, 32'h0);
        do_kick();
        repeat (30) @(negedge clk);
        // R2
        chk(cnt_req == 0 && rx_q.size() == 0, "R2", cnt_req, 0);
        chk(rd_word(32'h4000) == 32'h88000002, "R2", rd_word(32'h4000), 32'h88000002);
        @(negedge clk) enable = 1'b1;
        do_kick(); wait_idle();
        chk(cnt_buf == 1 && rx_q.size() == 2, "R2", cnt_buf, 1);
    endtask

    task automatic t_babble();
        clear_obs();
        set_base(32'h5000);
        set_desc(32'h5000, 16'h8000, 16'd2000, 32'h110000);
        set_desc(32'h5008, 16'h8800, 16'd100, 32'h120000);
        set_desc(32'h5010, 16'h0000, 16'd0, 32'h0);
        expect_bytes(32'h110000, 2000, 0);
        expect_bytes(32'h120000, 32, 1);
        do_kick(); wait_idle();
        cmp_stream("R10 trimmed frame");
        // R10
        chk(cnt_bab == 1 && cnt_frame == 1, "R10", {cnt_bab, cnt_frame}, 64'h100000001);
        chk(rd_word(32'h5008) == 32'h08000064, "R10", rd_word(32'h5008), 32'h08000064);
        clear_obs();
        set_desc(32'h5010, 16'h8800, 16'd10, 32'h130000);
        set_desc(32'h5018, 16'h0000, 16'd0, 32'h0);
        expect_bytes(32'h130000, 10, 1);
        do_kick(); wait_idle();
        cmp_stream("R10 count restarts");
        chk(cnt_bab == 0, "R10", cnt_bab, 0);
    endtask

    task automatic t_pending();
        clear_obs();
        set_base(32'h6000);
        set_desc(32'h6000, 16'h8800, 16'd8, 32'h100900);
        set_desc(32'h6008, 16'h0000, 16'd0, 32'h0);
        expect_bytes(32'h100900, 8, 1);
        expect_bytes(32'h100A00, 3, 1);
        stall_hold = 1;
        do_kick();
        while (!tx_valid) @(negedge clk);
        do_kick();
        stall_hold = 0;
        do @(posedge clk); while (!(mem_req && !mem_we && mem_addr == 32'h6008 && mem_ack));
        @(negedge clk) set_desc(32'h6008, 16'h8800, 16'd3, 32'h100A00);
        wait_idle();
        // R12
        cmp_stream("R12 pending kick");
        chk(cnt_buf == 2 && cnt_frame == 2, "R12", {cnt_buf, cnt_frame}, 64'h200000002);
    endtask

    task automatic t_maxdesc();
        clear_obs();
        set_base(32'h20000);
        for (int i = 0; i < 1026; i++)
            set_desc(32'h20000 + 8 * i, 16'h8800, 16'd0, 32'h100000);
        set_desc(32'h20000 + 8 * 1026, 16'h0000, 16'd0, 32'h0);
        do_kick(); wait_idle();
        // R11
        chk(cnt_buf == 1024, "R11", cnt_buf, 1024);
        chk(rd_word(32'h20000 + 8 * 1023) == 32'h08000000, "R11", rd_word(32'h20000 + 8 * 1023), 32'h08000000);
        chk(rd_word(32'h20000 + 8 * 1024) == 32'h88000000, "R11", rd_word(32'h20000 + 8 * 1024), 32'h88000000);
        clear_obs();
        do_kick(); wait_idle();
        chk(cnt_buf == 2 && rx_q.size() == 0, "R11", cnt_buf, 2);
    endtask

    initial begin
        clear_obs();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single();
        t_multi();
        t_wrap();
        t_disabled();
        t_babble();
        t_pending();
        t_maxdesc();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule